// File: doc/BRIEF.md
# Sticky Interrupt Status Register

This block is a single memory-mapped status word that gathers four board-level interrupt conditions and folds them into one interrupt request line for the processor. Three of the conditions arrive as one-cycle event pulses and are held in sticky flags: impending power loss, a memory error from either of two independent memory-side reporters, and a write error. The fourth condition, a posted halt request, is shown as a live level.

Software reads the word to find out why the interrupt line is asserted. It rearms a sticky condition by writing zero to that condition's bit. When a write error is first latched, the block also stores the address that came with it. That address stays valid for as long as the write-error flag is set, so later write errors do not overwrite the first one.

The register-access bus is outside this block. Only a write strobe with the three rearmable data bits comes in, and the full read word goes out continuously.

Top module: `irq_status_reg`

## Requirements
- R1: Read bits 31:4 of `rd_data_o` are always one.
- R2: Read bit 3 equals `halt_req_i` in the same cycle, with no latching.
- R3: A pulse on `pwrfail_evt_i` sets read bit 2 from the next cycle on. Bit 2 stays set, whatever further events arrive, until a write with `wr_data_i[2]`=0 clears it one cycle after the write.
- R4: A pulse on `memerr_a_evt_i`, on `memerr_b_evt_i`, or on both sets read bit 1 from the next cycle on. Bit 1 is cleared one cycle after a write with `wr_data_i[1]`=0.
- R5: A pulse on `wrerr_evt_i` sets read bit 0 from the next cycle on. Bit 0 is cleared one cycle after a write with `wr_data_i[0]`=0.
- R6: After reset, read bits 2:0 are zero and `wrerr_addr_o` is zero.
- R7: A write with a data bit of 1 leaves that sticky bit unchanged. An event in the same cycle as a clearing write wins, and the bit stays set.
- R8: `wrerr_addr_o` loads `wrerr_addr_i` only on a write-error event while read bit 0 is zero. The new value is visible on the next cycle. Later events leave the captured address as it is until bit 0 has been cleared.
- R9: `irq_o` is the OR of read bits 3:0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| halt_req_i | input | 1 | Halt request level |
| pwrfail_evt_i | input | 1 | Power-fail event pulse |
| memerr_a_evt_i | input | 1 | Memory error pulse, first reporter |
| memerr_b_evt_i | input | 1 | Memory error pulse, second reporter |
| wrerr_evt_i | input | 1 | Write-error event pulse |
| wrerr_addr_i | input | ADDR_W | Address that goes with the write-error event |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 3 | Write data for bits 2:0 (0 clears, 1 keeps) |
| rd_data_o | output | DATA_W | Status word |
| wrerr_addr_o | output | ADDR_W | Captured write-error address |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The halt bit and `irq_o` are combinational, so the bench compares them in the same low clock phase in which it drives the inputs. Every sticky bit and the captured address go through exactly one register. An event or clearing write driven before a rising edge therefore shows up at the next falling edge. The behavioural model updates on that same rising edge, and every output is compared once per cycle, halfway through the low phase, after the inputs have settled.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int STICKY_N = 3;
  localparam int IDX_WRERR = 0;
  localparam int IDX_MEMERR = 1;
  localparam int IDX_PWRFAIL = 2;
  localparam int IDX_HALT = 3;
  localparam int FLAG_N = 4;

  // next value of a set-dominant, write-zero-to-clear flag
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  // low nibble of the status word
  function automatic logic [FLAG_N-1:0] flag_pack(input logic halt,
                                                  input logic [STICKY_N-1:0] sticky);
    return {halt, sticky};
  endfunction
endpackage

// File: rtl/irq_evt_merge.sv
module irq_evt_merge
  import irq_stat_pkg::*;
(
  input  logic                pwrfail_evt_i,
  input  logic                memerr_a_evt_i,
  input  logic                memerr_b_evt_i,
  input  logic                wrerr_evt_i,
  output logic [STICKY_N-1:0] set_o
);
  always_comb begin
    set_o              = '0;
    set_o[IDX_PWRFAIL] = pwrfail_evt_i;
    set_o[IDX_MEMERR]  = memerr_a_evt_i | memerr_b_evt_i;
    set_o[IDX_WRERR]   = wrerr_evt_i;
  end
endmodule

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit
  import irq_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic rise_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= sticky_next(q_o, set_i, clr_i);
  end

  assign rise_o = set_i & ~q_o;
endmodule

// File: rtl/irq_addr_capture.sv
module irq_addr_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_o <= '0;
    else if (load_i) addr_o <= addr_i;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_req_i,
  input  logic                pwrfail_evt_i,
  input  logic                memerr_a_evt_i,
  input  logic                memerr_b_evt_i,
  input  logic                wrerr_evt_i,
  input  logic [ADDR_W-1:0]   wrerr_addr_i,
  input  logic                wr_en_i,
  input  logic [STICKY_N-1:0] wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [ADDR_W-1:0]   wrerr_addr_o,
  output logic                irq_o
);
  localparam int FILL_W = DATA_W - FLAG_N;

  // named internal events, observed by the bound checker
  logic [STICKY_N-1:0] set_evt;
  logic [STICKY_N-1:0] clr_req;
  logic [STICKY_N-1:0] sticky_q;
  logic [STICKY_N-1:0] rise_evt;
  logic                wrerr_rise;
  logic [FLAG_N-1:0]   flags;

  irq_evt_merge merge_i (
    .pwrfail_evt_i (pwrfail_evt_i),
    .memerr_a_evt_i(memerr_a_evt_i),
    .memerr_b_evt_i(memerr_b_evt_i),
    .wrerr_evt_i   (wrerr_evt_i),
    .set_o         (set_evt)
  );

  for (genvar g = 0; g < STICKY_N; g++) begin : g_flag
    assign clr_req[g] = wr_en_i & ~wr_data_i[g];
    irq_sticky_bit flag_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_evt[g]),
      .clr_i (clr_req[g]),
      .q_o   (sticky_q[g]),
      .rise_o(rise_evt[g])
    );
  end

  assign wrerr_rise = rise_evt[IDX_WRERR];

  irq_addr_capture #(.ADDR_W(ADDR_W)) addr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(wrerr_rise),
    .addr_i(wrerr_addr_i),
    .addr_o(wrerr_addr_o)
  );

  assign flags     = flag_pack(halt_req_i, sticky_q);
  assign rd_data_o = {{FILL_W{1'b1}}, flags};
  assign irq_o     = |flags;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt_req_i,
  input logic              pwrfail_evt_i,
  input logic              memerr_a_evt_i,
  input logic              memerr_b_evt_i,
  input logic              wrerr_evt_i,
  input logic [ADDR_W-1:0] wrerr_addr_i,
  input logic              wr_en_i,
  input logic [2:0]        wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [ADDR_W-1:0] wrerr_addr_o,
  input logic              irq_o,
  input logic              wrerr_rise
);
  AST_UPPER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    &rd_data_o[DATA_W-1:4]); // R1
  AST_HALT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[3] == halt_req_i); // R2
  AST_PWRFAIL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pwrfail_evt_i |=> rd_data_o[2]); // R3
  AST_PWRFAIL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[2] && !(wr_en_i && !wr_data_i[2]) |=> rd_data_o[2]); // R3
  AST_MEMERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (memerr_a_evt_i || memerr_b_evt_i) |=> rd_data_o[1]); // R4
  AST_WRERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !wr_data_i[0] && !wrerr_evt_i |=> !rd_data_o[0]); // R5
  AST_WRITE_ONE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_data_i[1] && rd_data_o[1] |=> rd_data_o[1]); // R7
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrerr_rise |=> wrerr_addr_o == $past(wrerr_addr_i)); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[0] |=> $stable(wrerr_addr_o)); // R8
  AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|rd_data_o[3:0])); // R9
endmodule

bind irq_status_reg irq_status_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .halt_req_i    (halt_req_i),
  .pwrfail_evt_i (pwrfail_evt_i),
  .memerr_a_evt_i(memerr_a_evt_i),
  .memerr_b_evt_i(memerr_b_evt_i),
  .wrerr_evt_i   (wrerr_evt_i),
  .wrerr_addr_i  (wrerr_addr_i),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .rd_data_o     (rd_data_o),
  .wrerr_addr_o  (wrerr_addr_o),
  .irq_o         (irq_o),
  .wrerr_rise    (wrerr_rise)
);

// File: tb/irq_status_reg_tb.sv
module irq_status_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt_req_i = 1'b0;
  logic        pwrfail_evt_i = 1'b0;
  logic        memerr_a_evt_i = 1'b0;
  logic        memerr_b_evt_i = 1'b0;
  logic        wrerr_evt_i = 1'b0;
  logic [31:0] wrerr_addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [31:0] wrerr_addr_o;
  logic        irq_o;

  int checks = 0;
  int fails = 0;

  // reference state
  bit          m_pf, m_me, m_we;
  logic [31:0] m_addr;

  always #10 clk = ~clk; // 50 MHz

  irq_status_reg dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt_req_i    (halt_req_i),
    .pwrfail_evt_i (pwrfail_evt_i),
    .memerr_a_evt_i(memerr_a_evt_i),
    .memerr_b_evt_i(memerr_b_evt_i),
    .wrerr_evt_i   (wrerr_evt_i),
    .wrerr_addr_i  (wrerr_addr_i),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .rd_data_o     (rd_data_o),
    .wrerr_addr_o  (wrerr_addr_o),
    .irq_o         (irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit any;
    any = halt_req_i | m_pf | m_me | m_we;
    check("R1 upper bits", {4'h0, rd_data_o[31:4]}, 32'h0FFF_FFFF);
    check("R2 halt bit", {31'd0, rd_data_o[3]}, {31'd0, halt_req_i});
    check("R3 power-fail bit", {31'd0, rd_data_o[2]}, {31'd0, m_pf});
    check("R4 memory-error bit", {31'd0, rd_data_o[1]}, {31'd0, m_me});
    check("R5 write-error bit", {31'd0, rd_data_o[0]}, {31'd0, m_we});
    check("R8 captured address", wrerr_addr_o, m_addr);
    check("R9 interrupt line", {31'd0, irq_o}, {31'd0, any});
  endtask

  // one cycle: drive in low phase, compare, step the model at the rising edge
  task automatic cyc(input bit h, input bit pf, input bit ma, input bit mb,
                     input bit we, input logic [31:0] a, input bit wen,
                     input logic [2:0] wd);
    bit clr_pf, clr_me, clr_we;
    halt_req_i = h; pwrfail_evt_i = pf; memerr_a_evt_i = ma;
    memerr_b_evt_i = mb; wrerr_evt_i = we; wrerr_addr_i = a;
    wr_en_i = wen; wr_data_i = wd;
    #5;
    compare_all();
    @(posedge clk);
    clr_pf = wen && (wd[2] == 1'b0);
    clr_me = wen && (wd[1] == 1'b0);
    clr_we = wen && (wd[0] == 1'b0);
    if (we && !m_we) m_addr = a;
    m_pf = pf ? 1'b1 : (clr_pf ? 1'b0 : m_pf);
    m_me = (ma || mb) ? 1'b1 : (clr_me ? 1'b0 : m_me);
    m_we = we ? 1'b1 : (clr_we ? 1'b0 : m_we);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 32'h0, 0, 3'b000);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_pf = 0; m_me = 0; m_we = 0; m_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R6: reset state
    check("R6 sticky bits after reset", {29'd0, rd_data_o[2:0]}, 32'd0);
    check("R6 address after reset", wrerr_addr_o, 32'd0);
    @(negedge clk);
    idle(2);

    // power-fail stickiness and rearm (R3, R7)
    cyc(0, 1, 0, 0, 0, 0, 0, 3'b000);
    idle(2);
    cyc(0, 1, 0, 0, 0, 0, 0, 3'b000);
    cyc(0, 0, 0, 0, 0, 0, 1, 3'b111);               // R7 write ones keeps
    check("R7 write one keeps power-fail", {31'd0, rd_data_o[2]}, 32'd1);
    cyc(0, 1, 0, 0, 0, 0, 1, 3'b000);               // R7 event beats clear
    check("R7 event wins over clear", {31'd0, rd_data_o[2]}, 32'd1);
    cyc(0, 0, 0, 0, 0, 0, 1, 3'b011);
    check("R3 cleared by zero write", {31'd0, rd_data_o[2]}, 32'd0);

    // memory error from either source (R4)
    cyc(0, 0, 1, 0, 0, 0, 0, 3'b000);
    cyc(0, 0, 0, 0, 0, 0, 1, 3'b101);
    cyc(0, 0, 0, 1, 0, 0, 0, 3'b000);
    cyc(0, 0, 1, 1, 0, 0, 1, 3'b000);
    cyc(0, 0, 0, 0, 0, 0, 1, 3'b000);
    idle(1);

    // write-error capture (R5, R8)
    cyc(0, 0, 0, 0, 1, 32'hA000_0010, 0, 3'b000);
    cyc(0, 0, 0, 0, 1, 32'hB000_0020, 0, 3'b000);
    check("R8 first address kept", wrerr_addr_o, 32'hA000_0010);
    cyc(0, 0, 0, 0, 0, 32'hC0, 1, 3'b110);
    cyc(0, 0, 0, 0, 1, 32'hC000_0030, 0, 3'b000);
    cyc(0, 0, 0, 0, 0, 0, 0, 3'b000);
    check("R8 reload after rearm", wrerr_addr_o, 32'hC000_0030);
    cyc(0, 0, 0, 0, 0, 0, 1, 3'b000);

    // halt level and interrupt line (R2, R9)
    cyc(1, 0, 0, 0, 0, 0, 0, 3'b000);
    cyc(1, 0, 0, 0, 0, 0, 1, 3'b000);
    cyc(0, 0, 0, 0, 0, 0, 0, 3'b000);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      cyc(($urandom % 4) == 0, ($urandom % 9) == 0, ($urandom % 9) == 0,
          ($urandom % 9) == 0, ($urandom % 7) == 0, $urandom,
          ($urandom % 4) == 0, 3'($urandom));
    end
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule